// File: doc/BRIEF.md
# Composite Vertical Blanking Flag Generator

This block drives a vertical-blanking indicator for composite digital video. An upstream line/sample counter supplies the current line number and the sample index within that line. A standard select picks NTSC or PAL timing, and a window-length select picks the short or the long blanking interval. The indicator is high inside two windows per frame, one per field.

Each window opens and closes at an exact sample position inside a line, not on a line boundary. The first window of each frame starts near the end of the previous frame and runs through the frame wrap. The output is registered, so it lags the counter inputs by one clock. The block does not generate the counts, does not decode timing reference words, and does not handle component standards. Position encoding: lines count from 1 (NTSC 1..525, PAL 1..625) and samples count from 0 (NTSC 0..909, PAL 0..1134).

Top module: `vblank_gen`

## Requirements
- R1: While rst_ni is low, vblank_o is 0 whatever the inputs.
- R2: vblank_o reflects the inputs sampled at the previous rising clock edge; there is exactly one clock of latency.
- R3: With pal_i=0 and short_i=1, vblank_o is 1 for positions from line 525 sample 768 through line 9 sample 767 inclusive, a range that wraps across the frame boundary.
- R4: With pal_i=0 and short_i=1, vblank_o is also 1 from line 263 sample 313 through line 272 sample 767 inclusive.
- R5: With pal_i=0 and short_i=0, the window ends move to line 19 sample 767 and line 282 sample 767; the start points stay as in R3 and R4.
- R6: With pal_i=1 and short_i=1, vblank_o is 1 from line 623 sample 382 through line 5 sample 947, and from line 310 sample 948 through line 317 sample 947, inclusive.
- R7: With pal_i=1 and short_i=0, the window ends move to line 15 sample 947 and line 327 sample 947.
- R8: At every position outside the selected windows, vblank_o is 0.
- R9: pal_i and short_i are evaluated every clock; a change of either applies at the next output update with no settling delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 10 | Current line number, from 1 |
| sample_i | input | 11 | Current sample within the line, from 0 |
| pal_i | input | 1 | 1 = PAL timing, 0 = NTSC timing |
| short_i | input | 1 | 1 = short blanking interval, 0 = long |
| vblank_o | output | 1 | Registered vertical-blanking flag |

## Verification
The bench sweeps every sample of the lines on both sides of each window edge in all four mode combinations, so a comparator that is off by one sample, uses exclusive bounds, or compares only the line number shows up as a single wrong cycle at the edge. Sweeping the last frame line into line 1 catches a first-field window that was treated as a plain range and therefore came out empty. Toggling the length select every clock inside the region where the two ends differ catches a design that latches the mode, and a directed transition exposes an extra or missing pipeline register.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  parameter int LINE_W = 10;
  parameter int SAMP_W = 11;
  parameter int NWIN   = 2;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [SAMP_W-1:0] samp;
  } pos_t;

  function automatic pos_t mk_pos(int unsigned l, int unsigned s);
    pos_t p;
    p.line = LINE_W'(l);
    p.samp = SAMP_W'(s);
    return p;
  endfunction
endpackage

// File: rtl/vbl_edge_sel.sv
module vbl_edge_sel
  import vbl_pkg::*;
(
  input  logic               pal_i,
  input  logic               short_i,
  output pos_t [NWIN-1:0]    start_o,
  output pos_t [NWIN-1:0]    stop_o
);
  always_comb begin
    if (pal_i) begin
      start_o[0] = mk_pos(623, 382);
      start_o[1] = mk_pos(310, 948);
      stop_o[0]  = short_i ? mk_pos(5, 947)   : mk_pos(15, 947);
      stop_o[1]  = short_i ? mk_pos(317, 947) : mk_pos(327, 947);
    end else begin
      start_o[0] = mk_pos(525, 768);
      start_o[1] = mk_pos(263, 313);
      stop_o[0]  = short_i ? mk_pos(9, 767)   : mk_pos(19, 767);
      stop_o[1]  = short_i ? mk_pos(272, 767) : mk_pos(282, 767);
    end
  end
endmodule

// File: rtl/vbl_win_cmp.sv
module vbl_win_cmp
  import vbl_pkg::*;
(
  input  pos_t cur_i,
  input  pos_t start_i,
  input  pos_t stop_i,
  output logic hit_o
);
  logic wraps, ge_start, le_stop;
  // line is the MSB field, so a packed compare is a raster-order compare
  assign wraps    = start_i > stop_i;
  assign ge_start = cur_i >= start_i;
  assign le_stop  = cur_i <= stop_i;
  assign hit_o    = wraps ? (ge_start | le_stop) : (ge_start & le_stop);
endmodule

// File: rtl/vblank_gen.sv
module vblank_gen
  import vbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [SAMP_W-1:0] sample_i,
  input  logic              pal_i,
  input  logic              short_i,
  output logic              vblank_o
);
  pos_t            cur;
  pos_t [NWIN-1:0] win_start, win_stop;
  logic [NWIN-1:0] hit;

  assign cur.line = line_i;
  assign cur.samp = sample_i;

  vbl_edge_sel i_edge_sel (
    .pal_i   (pal_i),
    .short_i (short_i),
    .start_o (win_start),
    .stop_o  (win_stop)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    vbl_win_cmp i_cmp (
      .cur_i   (cur),
      .start_i (win_start[w]),
      .stop_i  (win_stop[w]),
      .hit_o   (hit[w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vblank_o <= 1'b0;
    else         vblank_o <= |hit;
  end
endmodule

// File: rtl/vbl_checker.sv
module vbl_checker
  import vbl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] line_i,
  input logic [SAMP_W-1:0] sample_i,
  input logic              pal_i,
  input logic              short_i,
  input logic              vblank_o
);
  // R3: line 1 is deep inside the wrapped first window
  p_wrap_core_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pal_i && line_i == 1) |=> vblank_o);
  // R4
  p_field2_core_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pal_i && line_i == 268) |=> vblank_o);
  // R5: line 15 blanked only with the long select
  p_long_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pal_i && line_i == 15) |=> (vblank_o == !$past(short_i)));
  // R6
  p_pal_core_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_i && (line_i == 1 || line_i == 314)) |=> vblank_o);
  // R7
  p_pal_long_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_i && line_i == 320) |=> (vblank_o == !$past(short_i)));
  // R8
  p_mid_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i >= 100 && line_i <= 200) |=> !vblank_o);
endmodule

bind vblank_gen vbl_checker i_chk (.*);

// File: tb/test_vblank_gen.sv
module test_vblank_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  line_i = '0;
  logic [10:0] sample_i = '0;
  logic        pal_i = 1'b0;
  logic        short_i = 1'b1;
  logic        vblank_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit exp_q[$];
  string tag_q[$];

  vblank_gen i_vblank_gen (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) cyc++;

  function automatic bit ref_v(int l, int s, bit pal, bit sh);
    int p, a0, b0, a1, b1;
    p = l * 4096 + s;
    if (pal) begin
      a0 = 623*4096 + 382; b0 = (sh ? 5 : 15)*4096 + 947;
      a1 = 310*4096 + 948; b1 = (sh ? 317 : 327)*4096 + 947;
    end else begin
      a0 = 525*4096 + 768; b0 = (sh ? 9 : 19)*4096 + 767;
      a1 = 263*4096 + 313; b1 = (sh ? 272 : 282)*4096 + 767;
    end
    return (p >= a0 || p <= b0) || (p >= a1 && p <= b1);
  endfunction

  function automatic string auto_tag(int l, bit pal, bit sh);
    if (l >= 100 && l <= 200) return "R8";
    if (pal) return sh ? "R6" : "R7";
    if (!sh) return "R5";
    return (l > 200 && l < 400) ? "R4" : "R3";
  endfunction

  // one cycle: compare previous result, then drive next inputs (at negedge)
  task automatic step(int l, int s, bit pal, bit sh, string tag);
    @(negedge clk_i);
    if (exp_q.size() > 0) begin
      bit e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (vblank_o !== e) begin
        errors++;
        $display("FAIL %s: vblank_o=%0b expected %0b (cycle %0d)", t, vblank_o, e, cyc);
      end
    end
    line_i = 10'(l); sample_i = 11'(s); pal_i = pal; short_i = sh;
    exp_q.push_back(ref_v(l, s, pal, sh));
    tag_q.push_back(tag == "" ? auto_tag(l, pal, sh) : tag);
  endtask

  task automatic sweep_line(int l, bit pal, bit sh);
    int ns;
    ns = pal ? 1135 : 910;
    for (int s = 0; s < ns; s++) step(l, s, pal, sh, "");
  endtask

  task automatic sweep_mode(bit pal, bit sh);
    int lines[$];
    if (pal) lines = '{624, 625, 1, 2, 4, 5, 6, 14, 15, 16, 309, 310, 311, 316, 317, 318, 326, 327, 328, 150};
    else     lines = '{524, 525, 1, 2, 8, 9, 10, 18, 19, 20, 262, 263, 264, 271, 272, 273, 281, 282, 283, 150};
    foreach (lines[i]) sweep_line(lines[i], pal, sh);
  endtask

  initial begin
    fork
      begin
        // R1: in-window inputs during reset must not raise the flag
        line_i = 10'd1; sample_i = 11'd0;
        for (int i = 0; i < 4; i++) begin
          @(negedge clk_i);
          checks++;
          if (vblank_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: vblank_o=%0b expected 0 in reset", vblank_o);
          end
        end
        rst_ni = 1'b1;
        // R2: directed edge, output must trail input by exactly one clock
        step(150, 0, 1'b0, 1'b1, "R2");
        step(1, 0, 1'b0, 1'b1, "R2");
        step(1, 1, 1'b0, 1'b1, "R2");
        step(150, 0, 1'b0, 1'b1, "R2");
        step(150, 1, 1'b0, 1'b1, "R2");
        for (int m = 0; m < 4; m++) sweep_mode(m[1], m[0]);
        // R9: toggle selects every clock where they change the answer
        for (int s = 0; s < 200; s++) step(15, s, 1'b0, s[0], "R9");
        for (int s = 0; s < 200; s++) step(320, s, 1'b1, ~s[0], "R9");
        for (int s = 0; s < 100; s++) step(5, 900 + s, s[1], s[0], "R9");
        step(150, 0, 1'b0, 1'b1, "R8");
        step(150, 0, 1'b0, 1'b1, "R8");
      end
      begin
        while (cyc < 190000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule